// File: doc/BRIEF.md
# Page-Granular Set-Associative Tag Array

This block is the tag store of one slice of a large DRAM cache whose line is a whole 2-Kbyte page. A lookup takes a request address and a read/write flag. The block reads every way of the addressed set at once and compares them all. Two cycles after a request is accepted, it reports a hit or a miss.

On a hit, the response gives the matching way. On a miss, it gives the way to replace. If that way holds a page, the response also gives the page's dirty state and its base address, which the memory side needs to write the page back.

Each set keeps per-way valid and dirty bits, one tag per page and a three-bit tree pseudo-LRU. A separate fill port installs a page once it has arrived from local memory. Address interleaving across slices happens upstream, so the block never needs state from another slice.

Top module: `page_tag_array`

## Requirements
- R1: After reset every way of every set is invalid, no response is pending and `req_ready_o` is high. The first lookup of any set therefore misses with victim way 0 and `rsp_evict_valid_o` low.
- R2: Each accepted request (`req_valid_i && req_ready_o` at a clock edge) produces exactly one response, with `rsp_valid_o` high for one cycle, two clock edges after acceptance. Requests may be accepted on back-to-back cycles. While `rsp_valid_o` is low, `rsp_hit_o`, `rsp_evict_valid_o` and `rsp_evict_dirty_o` are low.
- R3: A lookup hits when a valid way of the set holds the request tag. The response then gives that way on `rsp_way_o`, with `rsp_evict_valid_o` and `rsp_evict_dirty_o` low.
- R4: The address is split into three fields. Bits [OFFSET_W-1:0] are the in-page offset and have no effect. The next SET_W bits select the set. The remaining upper bits are the tag. The same tag in a different set does not hit.
- R5: On a miss in a set with at least one invalid way, the victim is the lowest-numbered invalid way, and `rsp_evict_valid_o` is low.
- R6: On a miss in a full set, the victim is chosen by the tree bits {t2,t1,t0}. If t0=0, the victim is way 0 when t1=0 and way 1 when t1=1. If t0=1, the victim is way 2 when t2=0 and way 3 when t2=1. Reset leaves the tree at 000.
- R7: A hit and a fill each update the tree for the way used. t0 is set to point at the other half of the set, and that half's leaf bit is set to point at the other way of the pair.
- R8: A write hit marks the way dirty. A read hit leaves the dirty bit unchanged.
- R9: A fill to (set, way) makes the way valid with the fill tag. Its dirty bit takes `fill_dirty_i`: 1 for a write-allocate, 0 for a clean fill. A fill replaces whatever page was there before.
- R10: When a miss victim holds a page, `rsp_evict_valid_o` is high and `rsp_evict_dirty_o` gives its dirty bit. `rsp_evict_addr_o` gives its page base address {victim tag, set, OFFSET_W zeros}; otherwise this address is zero.
- R11: `req_ready_o` is low exactly when `fill_valid_i` is high and the fill set equals the request set. A request held through such a stall is accepted after the fill and sees the installed page.
- R12: A miss changes no state: repeating the lookup returns the same victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Lookup can be accepted this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_write_i | input | 1 | Request is a write |
| rsp_valid_o | output | 1 | Lookup result present |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | 2 | Hit way, or victim way on a miss |
| rsp_evict_valid_o | output | 1 | Miss victim holds a page |
| rsp_evict_dirty_o | output | 1 | Miss victim page needs write-back |
| rsp_evict_addr_o | output | ADDR_W | Base address of the victim page |
| fill_valid_i | input | 1 | Install a page this cycle |
| fill_addr_i | input | ADDR_W | Address of the page being installed |
| fill_way_i | input | 2 | Way receiving the page |
| fill_dirty_i | input | 1 | Install the page already dirty |

## Verification
The bench builds the block with a 30-bit address, an 11-bit offset and a 4-bit set index, which gives 16 sets and 15-bit tags. The tag width is the same as in a full-size slice, so the victim addresses use the real tag field.

With this few sets, the bench can fill a set completely and walk its pseudo-LRU tree through several hit and fill orders. It also keeps other sets untouched for the cold-miss, write-allocate and stall scenarios. Back-to-back requests to different sets exercise the fixed two-cycle latency.

// File: rtl/page_tag_pkg.sv
package page_tag_pkg;

  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = 2;
  localparam int unsigned PLRU_W   = NUM_WAYS - 1;

  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [PLRU_W-1:0] plru_t;

  // Tree layout: bit 0 picks the half (0 = ways 0/1), bit 1 picks within
  // the low pair, bit 2 picks within the high pair.
  function automatic way_t plru_victim(plru_t t);
    way_t w;
    if (t[0]) w = {1'b1, t[2]};
    else      w = {1'b0, t[1]};
    return w;
  endfunction

  // Point every node on the used path away from the used way.
  function automatic plru_t plru_touch(plru_t t, way_t w);
    plru_t r;
    r    = t;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction

endpackage

// File: rtl/page_tag_store.sv
module page_tag_store
  import page_tag_pkg::*;
#(
  parameter int unsigned SET_W = 8,
  parameter int unsigned TAG_W = 15
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SET_W-1:0]                 rd_set_i,
  output logic [NUM_WAYS-1:0]              rd_valid_o,
  output logic [NUM_WAYS-1:0]              rd_dirty_o,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag_o,
  output plru_t                            rd_plru_o,
  input  logic                             hit_en_i,
  input  logic [SET_W-1:0]                 hit_set_i,
  input  way_t                             hit_way_i,
  input  logic                             hit_write_i,
  input  logic                             fill_en_i,
  input  logic [SET_W-1:0]                 fill_set_i,
  input  way_t                             fill_way_i,
  input  logic [TAG_W-1:0]                 fill_tag_i,
  input  logic                             fill_dirty_i
);

  localparam int unsigned SETS = 1 << SET_W;

  logic [NUM_WAYS-1:0]            valid_q [SETS];
  logic [NUM_WAYS-1:0]            dirty_q [SETS];
  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  plru_t                          plru_q  [SETS];

  plru_t plru_hit_nxt;
  plru_t plru_fill_base;
  plru_t plru_fill_nxt;
  logic  dirty_set_en;

  // Read port and next-state of the replacement tree. When a hit and a fill
  // touch the same set in one cycle, the fill is applied on top of the hit.
  always_comb begin
    rd_valid_o     = valid_q[rd_set_i];
    rd_dirty_o     = dirty_q[rd_set_i];
    rd_tag_o       = tag_q[rd_set_i];
    rd_plru_o      = plru_q[rd_set_i];
    plru_hit_nxt   = plru_touch(plru_q[hit_set_i], hit_way_i);
    plru_fill_base = (hit_en_i && (hit_set_i == fill_set_i)) ? plru_hit_nxt
                                                              : plru_q[fill_set_i];
    plru_fill_nxt  = plru_touch(plru_fill_base, fill_way_i);
    dirty_set_en   = hit_en_i && hit_write_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      if (hit_en_i) begin
        plru_q[hit_set_i] <= plru_hit_nxt;
      end
      if (fill_en_i) begin
        plru_q[fill_set_i]              <= plru_fill_nxt;
        valid_q[fill_set_i][fill_way_i] <= 1'b1;
      end
    end
  end

  // Tag and dirty contents only matter once a way is valid: no reset.
  always_ff @(posedge clk_i) begin
    if (dirty_set_en) begin
      dirty_q[hit_set_i][hit_way_i] <= 1'b1;
    end
    if (fill_en_i) begin
      dirty_q[fill_set_i][fill_way_i] <= fill_dirty_i;
      tag_q[fill_set_i][fill_way_i]   <= fill_tag_i;
    end
  end

endmodule

// File: rtl/page_tag_match.sv
module page_tag_match
  import page_tag_pkg::*;
#(
  parameter int unsigned TAG_W = 15
) (
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]               cmp_tag_i,
  output logic                           hit_o,
  output way_t                           way_o
);

  logic [NUM_WAYS-1:0] match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == cmp_tag_i);
  end

  always_comb begin
    hit_o = |match;
    way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = way_t'(w);
    end
  end

endmodule

// File: rtl/page_victim_pick.sv
module page_victim_pick
  import page_tag_pkg::*;
#(
  parameter int unsigned TAG_W = 15
) (
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [NUM_WAYS-1:0]            dirty_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_i,
  input  plru_t                          plru_i,
  output way_t                           way_o,
  output logic                           occupied_o,
  output logic                           dirty_o,
  output logic [TAG_W-1:0]               tag_o
);

  way_t free_way;
  way_t pick;
  logic set_full;

  always_comb begin
    free_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = way_t'(w);
    end
    set_full   = &valid_i;
    pick       = set_full ? plru_victim(plru_i) : free_way;
    way_o      = pick;
    occupied_o = valid_i[pick];
    dirty_o    = valid_i[pick] && dirty_i[pick];
    tag_o      = tag_i[pick];
  end

endmodule

// File: rtl/page_tag_array.sv
module page_tag_array
  import page_tag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 34,
  parameter int unsigned OFFSET_W = 11,
  parameter int unsigned SET_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [1:0]        rsp_way_o,
  output logic              rsp_evict_valid_o,
  output logic              rsp_evict_dirty_o,
  output logic [ADDR_W-1:0] rsp_evict_addr_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [1:0]        fill_way_i,
  input  logic              fill_dirty_i
);

  localparam int unsigned TAG_W = ADDR_W - SET_W - OFFSET_W;

  // Address fields
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] fill_set;
  logic [TAG_W-1:0] fill_tag;
  logic             unused_offsets;

  assign req_set        = req_addr_i[OFFSET_W +: SET_W];
  assign req_tag        = req_addr_i[ADDR_W-1 -: TAG_W];
  assign fill_set       = fill_addr_i[OFFSET_W +: SET_W];
  assign fill_tag       = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_offsets = ^{req_addr_i[OFFSET_W-1:0], fill_addr_i[OFFSET_W-1:0]};

  // Acceptance
  logic accept;
  assign req_ready_o = !(fill_valid_i && (fill_set == req_set));
  assign accept      = req_valid_i && req_ready_o;

  // Stage 1: registered request
  logic             s1_valid_q, s1_valid_d;
  logic [SET_W-1:0] s1_set_q,   s1_set_d;
  logic [TAG_W-1:0] s1_tag_q,   s1_tag_d;
  logic             s1_write_q, s1_write_d;

  always_comb begin
    s1_valid_d = accept;
    s1_set_d   = s1_set_q;
    s1_tag_d   = s1_tag_q;
    s1_write_d = s1_write_q;
    if (accept) begin
      s1_set_d   = req_set;
      s1_tag_d   = req_tag;
      s1_write_d = req_write_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_valid_q <= 1'b0;
    else         s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk_i) begin
    s1_set_q   <= s1_set_d;
    s1_tag_q   <= s1_tag_d;
    s1_write_q <= s1_write_d;
  end

  // Tag storage and parallel compare
  logic [NUM_WAYS-1:0]            rd_valid;
  logic [NUM_WAYS-1:0]            rd_dirty;
  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  plru_t                          rd_plru;
  logic                           lk_hit;
  way_t                           lk_way;
  way_t                           vic_way;
  logic                           vic_occupied;
  logic                           vic_dirty;
  logic [TAG_W-1:0]               vic_tag;
  logic                           hit_en;

  assign hit_en = s1_valid_q && lk_hit;

  page_tag_store #(
    .SET_W (SET_W),
    .TAG_W (TAG_W)
  ) store_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_set_i     (s1_set_q),
    .rd_valid_o   (rd_valid),
    .rd_dirty_o   (rd_dirty),
    .rd_tag_o     (rd_tag),
    .rd_plru_o    (rd_plru),
    .hit_en_i     (hit_en),
    .hit_set_i    (s1_set_q),
    .hit_way_i    (lk_way),
    .hit_write_i  (s1_write_q),
    .fill_en_i    (fill_valid_i),
    .fill_set_i   (fill_set),
    .fill_way_i   (fill_way_i),
    .fill_tag_i   (fill_tag),
    .fill_dirty_i (fill_dirty_i)
  );

  page_tag_match #(
    .TAG_W (TAG_W)
  ) match_i (
    .valid_i   (rd_valid),
    .tag_i     (rd_tag),
    .cmp_tag_i (s1_tag_q),
    .hit_o     (lk_hit),
    .way_o     (lk_way)
  );

  page_victim_pick #(
    .TAG_W (TAG_W)
  ) victim_i (
    .valid_i    (rd_valid),
    .dirty_i    (rd_dirty),
    .tag_i      (rd_tag),
    .plru_i     (rd_plru),
    .way_o      (vic_way),
    .occupied_o (vic_occupied),
    .dirty_o    (vic_dirty),
    .tag_o      (vic_tag)
  );

  // Stage 2: registered response
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q,   rsp_hit_d;
  way_t              rsp_way_q,   rsp_way_d;
  logic              ev_valid_q,  ev_valid_d;
  logic              ev_dirty_q,  ev_dirty_d;
  logic [ADDR_W-1:0] ev_addr_q,   ev_addr_d;

  always_comb begin
    rsp_valid_d = s1_valid_q;
    rsp_hit_d   = 1'b0;
    rsp_way_d   = '0;
    ev_valid_d  = 1'b0;
    ev_dirty_d  = 1'b0;
    ev_addr_d   = '0;
    if (s1_valid_q) begin
      rsp_hit_d = lk_hit;
      rsp_way_d = lk_hit ? lk_way : vic_way;
      if (!lk_hit && vic_occupied) begin
        ev_valid_d = 1'b1;
        ev_dirty_d = vic_dirty;
        ev_addr_d  = {vic_tag, s1_set_q, {OFFSET_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_way_q   <= '0;
      ev_valid_q  <= 1'b0;
      ev_dirty_q  <= 1'b0;
      ev_addr_q   <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_way_q   <= rsp_way_d;
      ev_valid_q  <= ev_valid_d;
      ev_dirty_q  <= ev_dirty_d;
      ev_addr_q   <= ev_addr_d;
    end
  end

  assign rsp_valid_o       = rsp_valid_q;
  assign rsp_hit_o         = rsp_hit_q;
  assign rsp_way_o         = rsp_way_q;
  assign rsp_evict_valid_o = ev_valid_q;
  assign rsp_evict_dirty_o = ev_dirty_q;
  assign rsp_evict_addr_o  = ev_addr_q;

endmodule

// File: rtl/page_tag_array_chk.sv
module page_tag_array_chk #(
  parameter int unsigned SET_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [SET_W-1:0] req_set_i,
  input logic             fill_valid_i,
  input logic [SET_W-1:0] fill_set_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_evict_valid_o,
  input logic             rsp_evict_dirty_o
);

  logic acc_d1_q;
  logic acc_d2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_d1_q <= 1'b0;
      acc_d2_q <= 1'b0;
    end else begin
      acc_d1_q <= req_valid_i && req_ready_o;
      acc_d2_q <= acc_d1_q;
    end
  end

  assert_rsp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == acc_d2_q);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_evict_valid_o && !rsp_evict_dirty_o));

  assert_hit_no_evict_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> !rsp_evict_valid_o);

  assert_dirty_needs_page_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evict_dirty_o |-> rsp_evict_valid_o);

  assert_fill_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && (fill_set_i == req_set_i)) |-> !req_ready_o);

  assert_free_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i |-> req_ready_o);

endmodule

bind page_tag_array page_tag_array_chk #(
  .SET_W (SET_W)
) chk_i (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_valid_i       (req_valid_i),
  .req_ready_o       (req_ready_o),
  .req_set_i         (req_addr_i[OFFSET_W +: SET_W]),
  .fill_valid_i      (fill_valid_i),
  .fill_set_i        (fill_addr_i[OFFSET_W +: SET_W]),
  .rsp_valid_o       (rsp_valid_o),
  .rsp_hit_o         (rsp_hit_o),
  .rsp_evict_valid_o (rsp_evict_valid_o),
  .rsp_evict_dirty_o (rsp_evict_dirty_o)
);

// File: tb/page_tag_array_tb_top.sv
`timescale 1ns/1ps
module page_tag_array_tb_top;

  localparam int unsigned AW = 30;
  localparam int unsigned OW = 11;
  localparam int unsigned SW = 4;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_write;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [1:0]    rsp_way;
  logic          ev_valid;
  logic          ev_dirty;
  logic [AW-1:0] ev_addr;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic [1:0]    fill_way;
  logic          fill_dirty;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  page_tag_array #(.ADDR_W(AW), .OFFSET_W(OW), .SET_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way),
    .rsp_evict_valid_o(ev_valid), .rsp_evict_dirty_o(ev_dirty),
    .rsp_evict_addr_o(ev_addr),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr),
    .fill_way_i(fill_way), .fill_dirty_i(fill_dirty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] mk(input int tag, input int set, input int off);
    return {tag[14:0], set[3:0], off[10:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check_rsp(input string req, input logic hit, input logic [1:0] way,
                           input logic evv, input logic evd, input logic [AW-1:0] eva);
    chk(req, "rsp_valid", 64'(rsp_valid), 64'(1'b1));
    chk(req, "hit", 64'(rsp_hit), 64'(hit));
    chk(req, "way", 64'(rsp_way), 64'(way));
    chk(req, "evict_valid", 64'(ev_valid), 64'(evv));
    chk(req, "evict_dirty", 64'(ev_dirty), 64'(evd));
    chk(req, "evict_addr", 64'(ev_addr), 64'(eva));
  endtask

  task automatic lookup(input string req, input logic [AW-1:0] a, input logic wr,
                        input logic hit, input logic [1:0] way, input logic evv,
                        input logic evd, input logic [AW-1:0] eva);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "rsp_valid mid-pipe", 64'(rsp_valid), 64'(1'b0));
    @(negedge clk);
    check_rsp(req, hit, way, evv, evd, eva);
    @(negedge clk);
    chk("R2", "single response", 64'(rsp_valid), 64'(1'b0));
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic [1:0] w, input logic d);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = a;
    fill_way   = w;
    fill_dirty = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'(1'b0));
    chk("R1", "ready after reset", 64'(req_ready), 64'(1'b1));
    lookup("R1", mk(5, 3, 0), 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_hit_offsets();
    fill(mk(5, 3, 0), 2'd0, 1'b0);
    lookup("R9", mk(5, 3, 11'h7FF), 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    lookup("R4", mk(5, 3, 11'h123), 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, '0);  // write hit, R8
    lookup("R5", mk(6, 3, 0), 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, '0);
    lookup("R4", mk(5, 4, 0), 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_plru_walk();
    fill(mk(6, 3, 0), 2'd1, 1'b0);
    fill(mk(7, 3, 0), 2'd2, 1'b0);
    fill(mk(8, 3, 0), 2'd3, 1'b0);
    // tree 000 -> way 0, dirty from the earlier write hit (R8)
    lookup("R6", mk(9, 3, 0), 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, mk(5, 3, 0));
    lookup("R12", mk(9, 3, 0), 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, mk(5, 3, 0));
    lookup("R3", mk(5, 3, 0), 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    lookup("R7", mk(9, 3, 0), 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, mk(7, 3, 0));
    lookup("R3", mk(7, 3, 5), 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, '0);
    lookup("R7", mk(9, 3, 0), 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, mk(6, 3, 0));
  endtask

  task automatic t_read_clean();
    fill(mk(1, 7, 0), 2'd0, 1'b0);
    lookup("R8", mk(1, 7, 9), 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    fill(mk(2, 7, 0), 2'd1, 1'b0);
    fill(mk(3, 7, 0), 2'd2, 1'b0);
    fill(mk(4, 7, 0), 2'd3, 1'b0);
    lookup("R8", mk(20, 7, 0), 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, mk(1, 7, 0));
  endtask

  task automatic t_write_alloc();
    fill(mk(1, 9, 0), 2'd0, 1'b1);
    fill(mk(2, 9, 0), 2'd1, 1'b0);
    fill(mk(3, 9, 0), 2'd2, 1'b0);
    fill(mk(4, 9, 0), 2'd3, 1'b0);
    lookup("R9", mk(30, 9, 0), 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, mk(1, 9, 0));
    fill(mk(11, 9, 0), 2'd0, 1'b0);
    lookup("R9", mk(11, 9, 0), 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    lookup("R9", mk(1, 9, 0), 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, mk(3, 9, 0));
  endtask

  task automatic t_stall();
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = mk(3, 10, 0);
    fill_way   = 2'd0;
    fill_dirty = 1'b0;
    req_addr   = mk(3, 11, 0);
    req_write  = 1'b0;
    #1;
    chk("R11", "ready other set", 64'(req_ready), 64'(1'b1));
    req_valid = 1'b1;
    req_addr  = mk(3, 10, 4);
    #1;
    chk("R11", "ready same set", 64'(req_ready), 64'(1'b0));
    @(negedge clk);
    fill_valid = 1'b0;
    #1;
    chk("R11", "ready after fill", 64'(req_ready), 64'(1'b1));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "no early response", 64'(rsp_valid), 64'(1'b0));
    @(negedge clk);
    check_rsp("R11", 1'b1, 2'd0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = mk(8, 3, 0);
    req_write = 1'b0;
    @(negedge clk);
    req_addr  = mk(1, 12, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R2", 1'b1, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk);
    check_rsp("R2", 1'b0, 2'd0, 1'b0, 1'b0, '0);
    @(negedge clk);
    chk("R2", "pipe drained", 64'(rsp_valid), 64'(1'b0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_addr   = '0;
    req_write  = 1'b0;
    fill_valid = 1'b0;
    fill_addr  = '0;
    fill_way   = '0;
    fill_dirty = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit_offsets();
    t_plru_walk();
    t_read_clean();
    t_write_alloc();
    t_stall();
    t_back_to_back();
    finish_run();
  end

endmodule